// File: doc/BRIEF.md
# Watermark-Interrupt Mailbox FIFO

This block carries 32-bit words one way between two processors. A sender pushes words through a write port and a receiver pops them through a read port. Both ports sit behind a simple word-addressed register bus. Between the two ports is a small first-in first-out store.

Software picks a high watermark and a low watermark. The block compares the word count against each of them. Each comparison drives a status bit. Each status bit also drives a sticky interrupt-state bit that is set on the condition's rising edge. With these, a receiver can sleep until enough data has arrived, and a sender can sleep until enough space has freed up. The block also has:
- an enable register, which masks the two interrupt outputs;
- a test register, which sets state bits from software;
- an error register, which records overflow and underflow;
- a flush command, which empties the store.

Top module: `wm_mailbox`

## Requirements
- R1: The store holds DEPTH (default 8) words of 32 bits. Each read of the read port (word index 4, byte offset 0x10) returns the oldest stored word and removes it in the same access. A write to the write port (index 3, 0x0C) appends a word.
- R2: Registers are decoded on byte address bits [5:2]. The indexes are:
  - 0 interrupt state
  - 1 enable
  - 2 test
  - 3 write port
  - 4 read port
  - 5 status
  - 6 error
  - 7 high watermark
  - 8 low watermark
  - 9 flush

  Reads of any other index return zero. Writes to any other index change nothing.
- R3: The status register (index 5) has four bits:
  - bit 0 is set when the store is empty;
  - bit 1 is set when the store is full;
  - bit 2 is set when the count is greater than or equal to the high watermark;
  - bit 3 is set when the count is less than or equal to the low watermark.
- R4: Interrupt bit positions are the same in the state, enable and test registers: bit 0 error, bit 1 high watermark, bit 2 low watermark. A rising edge of status bit 2 sets state bit 1. A rising edge of status bit 3 sets state bit 2.
- R5: Writing a 1 to a state bit clears it. Writing a 0 leaves it unchanged.
- R6: Writing a 1 to a bit of the test register sets the matching state bit.
- R7: irq_hi equals state bit 1 AND enable bit 1. irq_lo equals state bit 2 AND enable bit 2. Both outputs are registered and change on the same edge as the state.
- R8: Overflow and underflow are errors.
  - A write to the write port while the store is full drops the word and sets error bit 0.
  - A read of the read port while the store is empty returns zero and sets error bit 1.
  - Error bits are sticky until reset. Either error sets state bit 0.
- R9: Any write to the flush register (index 9) empties the store in one cycle.
- R10: After reset, the following are zero: state, enable, both watermarks, the error register and the count. Both interrupt outputs are low.
- R11: A read request yields rsp_valid high with the data on the next cycle. A write request yields no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address; bits [5:2] select the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_hi | output | 1 | High-watermark interrupt request |
| irq_lo | output | 1 | Low-watermark interrupt request |

## Verification
Read data and the new count are due one cycle after the request edge. Error state bits are due on that same edge. A watermark edge caused by a count or watermark change reaches the state bits and irq outputs one edge later. The bench drives each access for one cycle, samples read data at the following falling edge, and then idles a full cycle before it inspects the outputs. This keeps every sample after the latest edge on which a result is due. Its reference model advances one settled step per access, in that same order.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] IDX_ISTATE = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_IEN    = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_ITEST  = 4'd2;
  localparam logic [REG_IDX_W-1:0] IDX_WPORT  = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_RPORT  = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_STATUS = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_ERROR  = 4'd6;
  localparam logic [REG_IDX_W-1:0] IDX_HIWM   = 4'd7;
  localparam logic [REG_IDX_W-1:0] IDX_LOWM   = 4'd8;
  localparam logic [REG_IDX_W-1:0] IDX_FLUSH  = 4'd9;
  localparam int unsigned NUM_IRQ = 3;
  localparam int unsigned IRQ_ERR = 0;
  localparam int unsigned IRQ_HI  = 1;
  localparam int unsigned IRQ_LO  = 2;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: the count never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst) count <= FULL_CNT);
  // R9: flush leaves the store empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst) flush |=> count == '0);
  // R1: a push without a pop grows the count by one
  a_r1_push_grows: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full && !flush) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic         test_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] hw_event,
  output logic [N-1:0] state,
  output logic [N-1:0] enable,
  output logic [N-1:0] pend
);
  logic [N-1:0] state_n, en_n, set_v, clr_v;

  assign set_v = hw_event | (test_we ? wdata : '0);
  assign clr_v = clr_we ? wdata : '0;

  always_comb begin
    state_n = (state & ~clr_v) | set_v;
    en_n    = en_we ? wdata : enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= '0;
      enable <= '0;
      pend   <= '0;
    end else begin
      state  <= state_n;
      enable <= en_n;
      pend   <= state_n & en_n;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: a cleared bit with nothing setting it reads back zero
    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr_v[i] && !set_v[i]) |=> !state[i]);
    // R6: a test write sets the bit
    a_r6_test_sets: assert property (@(posedge clk) disable iff (rst)
      (test_we && wdata[i]) |=> state[i]);
  end
endmodule

// File: rtl/wm_mailbox.sv
module wm_mailbox #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              irq_hi,
  output logic              irq_lo
);
  import mbx_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [REG_IDX_W-1:0] idx;
  logic wr, rd;
  logic [DW-1:0] head, rd_mux;
  logic [CW-1:0] count, hiwm, lowm;
  logic full, empty, hi_cond, lo_cond, hi_prev, lo_prev;
  logic ovf, unf;
  logic [1:0] err_q;
  logic [NUM_IRQ-1:0] ev, state, enable, pend;

  assign idx = req_addr[REG_IDX_W+1:2];
  assign wr  = req_valid && req_write;
  assign rd  = req_valid && !req_write;
  assign ovf = wr && idx == IDX_WPORT && full;
  assign unf = rd && idx == IDX_RPORT && empty;

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(wr && idx == IDX_WPORT),
    .pop(rd && idx == IDX_RPORT),
    .flush(wr && idx == IDX_FLUSH),
    .wdata(req_wdata), .head(head), .count(count), .full(full), .empty(empty)
  );

  assign hi_cond = (count >= hiwm);
  assign lo_cond = (count <= lowm);

  always_comb begin
    ev = '0;
    ev[IRQ_ERR] = ovf || unf;
    ev[IRQ_HI]  = hi_cond && !hi_prev;
    ev[IRQ_LO]  = lo_cond && !lo_prev;
  end

  mbx_irq #(.N(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst),
    .en_we(wr && idx == IDX_IEN),
    .clr_we(wr && idx == IDX_ISTATE),
    .test_we(wr && idx == IDX_ITEST),
    .wdata(req_wdata[NUM_IRQ-1:0]),
    .hw_event(ev), .state(state), .enable(enable), .pend(pend)
  );

  assign irq_hi = pend[IRQ_HI];
  assign irq_lo = pend[IRQ_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      hiwm    <= '0;
      lowm    <= '0;
      err_q   <= '0;
      hi_prev <= 1'b1;
      lo_prev <= 1'b1;
    end else begin
      hi_prev <= hi_cond;
      lo_prev <= lo_cond;
      if (ovf) err_q[0] <= 1'b1;
      if (unf) err_q[1] <= 1'b1;
      if (wr && idx == IDX_HIWM) hiwm <= req_wdata[CW-1:0];
      if (wr && idx == IDX_LOWM) lowm <= req_wdata[CW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_ISTATE: rd_mux[NUM_IRQ-1:0] = state;
      IDX_IEN:    rd_mux[NUM_IRQ-1:0] = enable;
      IDX_RPORT:  rd_mux = empty ? '0 : head;
      IDX_STATUS: rd_mux[3:0] = {lo_cond, hi_cond, full, empty};
      IDX_ERROR:  rd_mux[1:0] = err_q;
      IDX_HIWM:   rd_mux[CW-1:0] = hiwm;
      IDX_LOWM:   rd_mux[CW-1:0] = lowm;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  // R11: every read is answered on the next cycle
  a_r11_read_rsp: assert property (@(posedge clk) disable iff (rst) rd |=> rsp_valid);
  // R8: an underflow read answers zero
  a_r8_underflow_zero: assert property (@(posedge clk) disable iff (rst) unf |=> rsp_rdata == '0);
  // R8: a write into a full store keeps it full
  a_r8_overflow_keeps: assert property (@(posedge clk) disable iff (rst) ovf |=> full);
  // R4: a rising high condition latches the high state bit
  a_r4_hi_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_cond) |=> state[IRQ_HI]);
  // R4: a rising low condition latches the low state bit
  a_r4_lo_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_cond) |=> state[IRQ_LO]);
endmodule

// File: tb/wm_mailbox_bench.sv
module wm_mailbox_bench;
  localparam int DEPTH = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, irq_hi, irq_lo;
  logic [31:0] rsp_rdata;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference model
  logic [31:0] q[$];
  int hiwm = 0, lowm = 0;
  logic [2:0] st = 0, en = 0;
  logic [1:0] err = 0;
  bit hprev = 1, lprev = 1;

  always #10 clk = ~clk;

  wm_mailbox u_wm_mailbox (.clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_hi(irq_hi), .irq_lo(irq_lo));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    int c = q.size();
    return {28'd0, c <= lowm, c >= hiwm, c == DEPTH, c == 0};
  endfunction

  function automatic void settle();
    bit h = q.size() >= hiwm;
    bit l = q.size() <= lowm;
    if (h && !hprev) st[1] = 1;
    if (l && !lprev) st[2] = 1;
    hprev = h;
    lprev = l;
  endfunction

  task automatic bus(bit w, logic [5:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    r = rsp_rdata;
    if (!w) chk("R11 read response valid", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    logic [31:0] r;
    bus(1, a, d, r);
    case (a[5:2])
      4'd0: st = st & ~d[2:0];
      4'd1: en = d[2:0];
      4'd2: st = st | d[2:0];
      4'd3: if (q.size() == DEPTH) begin err[0] = 1; st[0] = 1; end else q.push_back(d);
      4'd7: hiwm = d[3:0];
      4'd8: lowm = d[3:0];
      4'd9: q.delete();
      default: ;
    endcase
    settle();
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] r);
    bus(0, a, 0, r);
    settle();
  endtask

  task automatic pop_chk(string req);
    logic [31:0] r, e;
    if (q.size() == 0) begin
      e = 0; err[1] = 1; st[0] = 1;
    end else e = q.pop_front();
    rd(6'h10, r);
    chk(req, r, e);
  endtask

  task automatic irq_chk(string req);
    chk(req, {30'd0, irq_lo, irq_hi}, {30'd0, st[2] & en[2], st[1] & en[1]});
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq outputs after reset", {30'd0, irq_lo, irq_hi}, 0);
    rd(6'h00, r); chk("R10 istate reset", r, 0);
    rd(6'h18, r); chk("R10 error reset", r, 0);
    rd(6'h1C, r); chk("R10 hiwater reset", r, 0);
    rd(6'h14, r); chk("R10 R3 status reset", r, exp_status());

    // R1 ordering across wrap, R3 status
    wr(6'h1C, 2); wr(6'h20, 1); wr(6'h04, 3'b110);
    for (int i = 0; i < 3; i++) wr(6'h0C, 32'hA000_0000 + i);
    rd(6'h14, r); chk("R3 status with 3 words", r, exp_status());
    chk("R4 hi state latched", {31'd0, st[1]}, 1);
    irq_chk("R7 irq after hi edge");
    rd(6'h00, r); chk("R4 istate readback", r, {29'd0, st});
    wr(6'h00, 3'b010); irq_chk("R5 hi cleared");
    rd(6'h00, r); chk("R5 istate after w1c", r, {29'd0, st});
    pop_chk("R1 pop oldest"); pop_chk("R1 pop second");
    rd(6'h00, r); chk("R4 lo edge latched", r, {29'd0, st});
    irq_chk("R7 irq_lo after lo edge");

    // R8 overflow / underflow
    for (int i = 0; i < 9; i++) wr(6'h0C, 32'hB000_0000 + i);
    rd(6'h18, r); chk("R8 overflow error bit", r, {30'd0, err});
    rd(6'h14, r); chk("R3 full status", r, exp_status());
    for (int i = 0; i < 8; i++) pop_chk("R1 R8 drain in order");
    pop_chk("R8 underflow returns zero");
    rd(6'h18, r); chk("R8 underflow error bit", r, {30'd0, err});
    rd(6'h00, r); chk("R8 error state bit", r, {29'd0, st});

    // R6 test register, R2 unmapped
    wr(6'h00, 3'b111); wr(6'h08, 3'b010); irq_chk("R6 test sets hi");
    wr(6'h28, 32'hFFFF_FFFF); wr(6'h3C, 32'h5);
    rd(6'h28, r); chk("R2 unmapped reads zero", r, 0);
    rd(6'h14, r); chk("R2 unmapped write ignored", r, exp_status());
    rd(6'h00, r); chk("R2 state untouched", r, {29'd0, st});

    // R9 flush
    for (int i = 0; i < 5; i++) wr(6'h0C, i);
    wr(6'h24, 0);
    rd(6'h14, r); chk("R9 flush empties", r, exp_status());
    pop_chk("R9 read after flush zero");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 4) wr(6'h0C, $urandom);
      else if (k < 7) pop_chk("R1 random pop");
      else if (k == 7) wr(6'h1C, $urandom_range(0, 8));
      else if (k == 8) wr(6'h20, $urandom_range(0, 8));
      else wr(6'h00, $urandom_range(0, 7));
      irq_chk("R7 random irq");
      if (n % 10 == 0) begin
        rd(6'h14, r); chk("R3 random status", r, exp_status());
        rd(6'h00, r); chk("R4 random istate", r, {29'd0, st});
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule